// File: doc/BRIEF.md
# Multi-Port Hardware Lock Bank

A lock bank lets several processors, each on its own register port, take turns using a shared resource such as a common console or a memory region. The bank holds a build-time number of lock entries. To claim an entry, a processor writes its own identity with the lock bit set. To find out whether the claim took hold, it reads the entry back and compares the returned owner with its own identity. While an entry is held, every other claimant keeps retrying. When the owner is done, it writes the entry with the lock bit cleared, and only a release that carries the recorded owner identity is accepted.

Every port offers single-cycle accesses on one shared clock. A port presents an access strobe, a write flag, an entry index and a write word. A read returns its word on the following cycle together with a valid pulse. The bank supports from one up to eight ports. When ports collide on one free entry in the same cycle, a fixed priority decides the winner. The asynchronous reset is released synchronously inside the block.

Top module: `hw_mutex_bank`

## Requirements
- R1: After reset every entry is free with owner field zero, every read returns zero, and no read-valid is asserted until a read is made.
- R2: A write whose word has the lock bit (bit ID_W, the top bit) set to 1 seizes a free entry and records the identity from bits ID_W-1:0 as its owner.
- R3: A write with the lock bit set to an entry that is already held changes neither its lock bit nor its owner, even when it carries the owner's own identity.
- R4: A write with the lock bit 0 whose identity equals the recorded owner frees the entry and clears its owner field to zero.
- R5: A write with the lock bit 0 whose identity differs from the recorded owner leaves a held entry unchanged.
- R6: A write with the lock bit 0 to a free entry leaves it free with owner zero.
- R7: When several ports write the lock bit set to the same free entry in one cycle, the port with the lowest index wins and its identity becomes the owner.
- R8: Claims from different ports to different entries in the same cycle all succeed independently.
- R9: A read (strobe high, write flag low) asserts that port's read-valid on the next cycle and returns {lock bit, owner} as they stood before any write of the cycle of the read. A write or an idle cycle gives read-valid low on the next cycle.
- R10: A claim made in the same cycle as the owner's release of that entry is ignored, so the entry ends that cycle free.
- R11: An access to an index at or above the number of entries changes no entry, and a read there returns zero with read-valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of all ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | NP | Access strobe, one bit per port |
| acc_we | input | NP | Write flag per port (1 = write, 0 = read) |
| acc_idx | input | NP*IW | Entry index per port, port p at bits p*IW +: IW |
| acc_wdata | input | NP*(ID_W+1) | Write word per port: lock bit on top, identity below |
| rd_valid | output | NP | Read-response valid per port |
| rd_data | output | NP*(ID_W+1) | Read word per port: lock bit on top, owner below |

## Verification
A write takes effect at the clock edge that samples it. Its effect on the entry is therefore visible to a read issued in the next cycle, and that read's data appears one cycle after the read. A read's response, like its valid pulse, is due exactly one edge after the read is presented, and it reflects the state from before that edge. The bench drives on the falling edge, predicts every port's response from a reference model of the state before the rising edge, and compares at the following falling edge. Each cycle of directed or random stimulus therefore checks the responses to the previous cycle's reads.

// File: rtl/hwmx_pkg.sv
package hwmx_pkg;
  localparam int unsigned HWMX_MAX_PORTS = 8;

  function automatic int unsigned idx_width(input int unsigned entries);
    return (entries > 1) ? $clog2(entries) : 1;
  endfunction
endpackage

// File: rtl/hwmx_rst_sync.sv
module hwmx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hwmx_decode.sv
module hwmx_decode #(
  parameter int unsigned NP   = 4,
  parameter int unsigned NL   = 6,
  parameter int unsigned ID_W = 4,
  parameter int unsigned IW   = 3,
  localparam int unsigned DW  = ID_W + 1
) (
  input  logic [NP-1:0]      acc_en,
  input  logic [NP-1:0]      acc_we,
  input  logic [NP*IW-1:0]   acc_idx,
  input  logic [NP*DW-1:0]   acc_wdata,
  output logic [NL*NP-1:0]   claim_mat,
  output logic [NL*NP-1:0]   rel_mat,
  output logic [NP*ID_W-1:0] port_ids
);
  always_comb begin
    claim_mat = '0;
    rel_mat   = '0;
    port_ids  = '0;
    for (int p = 0; p < NP; p++) begin
      port_ids[p*ID_W +: ID_W] = acc_wdata[p*DW +: ID_W];
      for (int e = 0; e < NL; e++) begin
        if (acc_en[p] && acc_we[p] && (acc_idx[p*IW +: IW] == IW'(e))) begin
          claim_mat[e*NP + p] =  acc_wdata[p*DW + ID_W];
          rel_mat[e*NP + p]   = !acc_wdata[p*DW + ID_W];
        end
      end
    end
  end
endmodule

// File: rtl/hwmx_entry.sv
module hwmx_entry #(
  parameter int unsigned NP   = 4,
  parameter int unsigned ID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP-1:0]     claim,
  input  logic [NP-1:0]     rel,
  input  logic [NP*ID_W-1:0] ids,
  output logic              lock_q,
  output logic [ID_W-1:0]   own_q
);
  logic            lock_d;
  logic [ID_W-1:0] own_d;
  logic            found;
  logic [ID_W-1:0] win_id;
  logic            rel_ok;
  logic            upd_en;

  // Lowest-numbered claimer wins; release needs the recorded owner id.
  always_comb begin
    found  = 1'b0;
    win_id = '0;
    rel_ok = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (!found && claim[p]) begin
        found  = 1'b1;
        win_id = ids[p*ID_W +: ID_W];
      end
      if (rel[p] && (ids[p*ID_W +: ID_W] == own_q)) rel_ok = 1'b1;
    end
  end

  always_comb begin
    lock_d = lock_q;
    own_d  = own_q;
    upd_en = 1'b0;
    if (!lock_q) begin
      if (found) begin
        lock_d = 1'b1;
        own_d  = win_id;
        upd_en = 1'b1;
      end
    end else if (rel_ok) begin
      lock_d = 1'b0;
      own_d  = '0;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      own_q  <= '0;
    end else if (upd_en) begin
      lock_q <= lock_d;
      own_q  <= own_d;
    end
  end
endmodule

// File: rtl/hwmx_readback.sv
module hwmx_readback #(
  parameter int unsigned NL   = 6,
  parameter int unsigned ID_W = 4,
  parameter int unsigned IW   = 3,
  localparam int unsigned DW  = ID_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [IW-1:0]      rd_idx,
  input  logic [NL-1:0]      lock_vec,
  input  logic [NL*ID_W-1:0] own_vec,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data
);
  logic [DW-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int e = 0; e < NL; e++) begin
      if (rd_idx == IW'(e)) sel_word = {lock_vec[e], own_vec[e*ID_W +: ID_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_req) rd_data <= sel_word;
  end
endmodule

// File: rtl/hw_mutex_bank.sv
module hw_mutex_bank #(
  parameter int unsigned NP   = 4,
  parameter int unsigned NL   = 6,
  parameter int unsigned ID_W = 4,
  localparam int unsigned IW  = hwmx_pkg::idx_width(NL),
  localparam int unsigned DW  = ID_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    acc_en,
  input  logic [NP-1:0]    acc_we,
  input  logic [NP*IW-1:0] acc_idx,
  input  logic [NP*DW-1:0] acc_wdata,
  output logic [NP-1:0]    rd_valid,
  output logic [NP*DW-1:0] rd_data
);
  logic               rst_sync_n;
  logic [NL*NP-1:0]   claim_mat;
  logic [NL*NP-1:0]   rel_mat;
  logic [NP*ID_W-1:0] port_ids;
  logic [NL-1:0]      lock_vec;
  logic [NL*ID_W-1:0] own_vec;

  initial begin
    if (NP < 1 || NP > hwmx_pkg::HWMX_MAX_PORTS) $error("hw_mutex_bank: NP out of range");
  end

  hwmx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hwmx_decode #(.NP(NP), .NL(NL), .ID_W(ID_W), .IW(IW)) u_dec (
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_idx   (acc_idx),
    .acc_wdata (acc_wdata),
    .claim_mat (claim_mat),
    .rel_mat   (rel_mat),
    .port_ids  (port_ids)
  );

  for (genvar e = 0; e < NL; e++) begin : g_ent
    hwmx_entry #(.NP(NP), .ID_W(ID_W)) u_ent (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .claim  (claim_mat[e*NP +: NP]),
      .rel    (rel_mat[e*NP +: NP]),
      .ids    (port_ids),
      .lock_q (lock_vec[e]),
      .own_q  (own_vec[e*ID_W +: ID_W])
    );
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    hwmx_readback #(.NL(NL), .ID_W(ID_W), .IW(IW)) u_rb (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .rd_req   (acc_en[p] & ~acc_we[p]),
      .rd_idx   (acc_idx[p*IW +: IW]),
      .lock_vec (lock_vec),
      .own_vec  (own_vec),
      .rd_valid (rd_valid[p]),
      .rd_data  (rd_data[p*DW +: DW])
    );
  end
endmodule

// File: rtl/hwmx_checker.sv
module hwmx_checker #(
  parameter int unsigned NP   = 4,
  parameter int unsigned NL   = 6,
  parameter int unsigned ID_W = 4,
  parameter int unsigned IW   = 3,
  localparam int unsigned DW  = ID_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NP-1:0]      acc_en,
  input logic [NP-1:0]      acc_we,
  input logic [NP*IW-1:0]   acc_idx,
  input logic [NP*DW-1:0]   acc_wdata,
  input logic [NL-1:0]      lock_vec,
  input logic [NL*ID_W-1:0] own_vec,
  input logic [NP-1:0]      rd_valid,
  input logic [NP*DW-1:0]   rd_data
);
  logic [NL-1:0] claim_seen;
  logic [NL-1:0] rel_seen;

  always_comb begin
    claim_seen = '0;
    rel_seen   = '0;
    for (int e = 0; e < NL; e++) begin
      for (int p = 0; p < NP; p++) begin
        if (acc_en[p] && acc_we[p] && acc_idx[p*IW +: IW] == IW'(e)) begin
          if (acc_wdata[p*DW + ID_W]) claim_seen[e] = 1'b1;
          else                        rel_seen[e]   = 1'b1;
        end
      end
    end
  end

  for (genvar e = 0; e < NL; e++) begin : g_e
    // R1
    free_owner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_vec[e] |-> own_vec[e*ID_W +: ID_W] == '0);
    // R2
    seize_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_vec[e]) |-> $past(claim_seen[e]));
    // R3
    held_owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_vec[e] && $past(lock_vec[e])) |-> own_vec[e*ID_W +: ID_W] == $past(own_vec[e*ID_W +: ID_W]));
    // R4
    free_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_vec[e]) |-> $past(rel_seen[e]));
  end

  for (genvar p = 0; p < NP; p++) begin : g_p
    // R9
    read_valid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en[p] && !acc_we[p]) |=> rd_valid[p]);
    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_en[p] && !acc_we[p]) |=> !rd_valid[p]);
    // R1
    read_free_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[p] && !rd_data[p*DW + ID_W]) |-> rd_data[p*DW +: ID_W] == '0);
  end
endmodule

bind hw_mutex_bank hwmx_checker #(.NP(NP), .NL(NL), .ID_W(ID_W), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_en    (acc_en),
  .acc_we    (acc_we),
  .acc_idx   (acc_idx),
  .acc_wdata (acc_wdata),
  .lock_vec  (lock_vec),
  .own_vec   (own_vec),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data)
);

// File: tb/hw_mutex_bank_bench.sv
`timescale 1ns/1ps
module hw_mutex_bank_bench;
  localparam int NP = 4;
  localparam int NL = 6;
  localparam int ID_W = 4;
  localparam int IW = 3;
  localparam int DW = ID_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    acc_en = '0;
  logic [NP-1:0]    acc_we = '0;
  logic [NP*IW-1:0] acc_idx = '0;
  logic [NP*DW-1:0] acc_wdata = '0;
  logic [NP-1:0]    rd_valid;
  logic [NP*DW-1:0] rd_data;

  always #2 clk = ~clk;

  hw_mutex_bank #(.NP(NP), .NL(NL), .ID_W(ID_W)) u_hw_mutex_bank (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  bit            m_lock [NL];
  bit [ID_W-1:0] m_own  [NL];

  // per-port drive for the next cycle
  bit            d_en  [NP];
  bit            d_we  [NP];
  bit [IW-1:0]   d_idx [NP];
  bit            d_lk  [NP];
  bit [ID_W-1:0] d_id  [NP];

  // expected responses
  bit          x_v [NP];
  bit [DW-1:0] x_d [NP];
  string       x_t [NP];

  function automatic bit [DW-1:0] model_word(input bit [IW-1:0] idx);
    if (idx >= NL) return '0;
    return {m_lock[idx], m_own[idx]};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_drive();
    for (int p = 0; p < NP; p++) begin
      d_en[p] = 0; d_we[p] = 0; d_idx[p] = '0; d_lk[p] = 0; d_id[p] = '0;
    end
  endtask

  task automatic set_port(input int p, input bit we, input int idx, input bit lk, input int id);
    d_en[p] = 1; d_we[p] = we; d_idx[p] = IW'(idx); d_lk[p] = lk; d_id[p] = ID_W'(id);
  endtask

  // One cycle: check last responses, drive, predict.
  task automatic step(input string tag);
    bit            n_lock [NL];
    bit [ID_W-1:0] n_own  [NL];
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check({x_t[p], " valid"}, DW'(rd_valid[p]), DW'(x_v[p]));
      if (x_v[p]) check({x_t[p], " data"}, rd_data[p*DW +: DW], x_d[p]);
    end
    for (int p = 0; p < NP; p++) begin
      acc_en[p] = d_en[p];
      acc_we[p] = d_we[p];
      acc_idx[p*IW +: IW] = d_idx[p];
      acc_wdata[p*DW +: DW] = {d_lk[p], d_id[p]};
      x_v[p] = d_en[p] && !d_we[p];
      x_d[p] = model_word(d_idx[p]);
      x_t[p] = tag;
    end
    for (int e = 0; e < NL; e++) begin
      bit won = 0;
      bit freed = 0;
      n_lock[e] = m_lock[e];
      n_own[e] = m_own[e];
      for (int p = 0; p < NP; p++) begin
        if (d_en[p] && d_we[p] && d_idx[p] == IW'(e)) begin
          if (!m_lock[e] && d_lk[p] && !won) begin
            won = 1; n_lock[e] = 1; n_own[e] = d_id[p];
          end
          if (m_lock[e] && !d_lk[p] && d_id[p] == m_own[e]) freed = 1;
        end
      end
      if (freed) begin n_lock[e] = 0; n_own[e] = '0; end
    end
    for (int e = 0; e < NL; e++) begin m_lock[e] = n_lock[e]; m_own[e] = n_own[e]; end
    clear_drive();
  endtask

  task automatic read_all(input string tag);
    for (int e = 0; e < NL; e += NP) begin
      for (int p = 0; p < NP; p++) if (e + p < NL) set_port(p, 0, e + p, 0, 0);
      step(tag);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_0042));
    for (int e = 0; e < NL; e++) begin m_lock[e] = 0; m_own[e] = '0; end
    for (int p = 0; p < NP; p++) begin x_v[p] = 0; x_d[p] = '0; x_t[p] = "R1"; end
    clear_drive();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step("R1");
    read_all("R1");
    // R2: claim entry 1 with id 5
    set_port(0, 1, 1, 1, 5); step("R2");
    set_port(1, 0, 1, 0, 0); step("R2");
    // R3: other id and same id claim a held entry
    set_port(1, 1, 1, 1, 7); step("R3");
    set_port(2, 1, 1, 1, 5); step("R3");
    set_port(0, 0, 1, 0, 0); step("R3");
    // R5: release from wrong id
    set_port(2, 1, 1, 0, 3); step("R5");
    set_port(3, 0, 1, 0, 0); step("R5");
    // R4: owner release
    set_port(0, 1, 1, 0, 5); step("R4");
    set_port(3, 0, 1, 0, 0); step("R4");
    // R6: release to free entry
    set_port(1, 1, 2, 0, 0); step("R6");
    set_port(1, 0, 2, 0, 0); step("R6");
    // R7: ports 1..3 collide on entry 3
    set_port(1, 1, 3, 1, 9); set_port(2, 1, 3, 1, 10); set_port(3, 1, 3, 1, 11); step("R7");
    set_port(0, 0, 3, 0, 0); step("R7");
    // R8: distinct entries at once
    set_port(0, 1, 0, 1, 1); set_port(1, 1, 2, 1, 2); set_port(2, 1, 4, 1, 3); set_port(3, 1, 5, 1, 4);
    step("R8");
    read_all("R8");
    // R10: owner release plus competing claim, entry 3
    set_port(0, 1, 3, 1, 12); set_port(3, 1, 3, 0, 9); step("R10");
    set_port(0, 0, 3, 0, 0); step("R10");
    // R9: read in the same cycle as a claim sees the old state
    set_port(0, 1, 3, 1, 6); set_port(1, 0, 3, 0, 0); step("R9");
    set_port(1, 0, 3, 0, 0); step("R9");
    // R11: out-of-range indices
    set_port(0, 1, 6, 1, 2); set_port(1, 1, 7, 0, 0); step("R11");
    set_port(2, 0, 6, 0, 0); set_port(3, 0, 7, 0, 0); step("R11");
    read_all("R11");
    // random mix
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < NP; p++) begin
        if (($urandom % 10) < 7)
          set_port(p, 1'($urandom), int'($urandom % 8), 1'($urandom), int'($urandom % 4));
      end
      step("R9");
    end
    step("R9");
    step("R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule